// File: doc/BRIEF.md
# Column Drain Selector for a Pixel Section Readout

This block sits at the periphery of a sensor section that is organised as a set of pixel columns. Each column raises a token line while it holds hits it has not delivered. It answers a one-cycle read request with a one-cycle valid pulse that carries a data packet. The selector picks one token-active column at a time and pulls packets out of it with read requests. For every packet returned, it writes one word into an output FIFO. The word holds the packet, the index of the column and a timestamp.

The timestamp of a column is taken when its token first appears, not when the packet is read. All packets drained from one token episode therefore carry the time at which the column first asked for service. A programmable cap on back-to-back reads keeps a busy column from starving the others. When the cap is reached, or when the column's token drops, service passes round-robin to the next column whose token is high. The selector never issues a request while the FIFO reports full.

Top module: `secReadoutCtrl`

## Requirements
- R1: While reset (`rstN` low) is asserted and after its release with no token high, `colReadReq` is all zero and `fifoWrite` is low.
- R2: In the first clock cycle in which a column's token is sampled high, the column's timestamp register captures `timestamp`. It is not recaptured while the token stays high. It becomes capturable again only after the token has been sampled low.
- R3: After leaving a column, the selector serves the next token-active column found by searching upward from the index after the one last served, wrapping around. After reset the search starts at column 0.
- R4: The selector issues at most `readLimit` consecutive reads to a column before switching. A `readLimit` of 0 behaves as 1. If the selected column is the only active one, it may be selected again after the switch.
- R5: When the selected column's token is low at the point of issuing, the selector issues no further read to it and moves on.
- R6: A read request is a single-cycle pulse, at most one bit of `colReadReq` is high, and it goes only to a column whose token is high. No request is issued while `fifoFull` is high. No new request is issued until the previous request has been answered by that column's `colValid`.
- R7: Each `colValid` pulse from the column being read produces exactly one `fifoWrite` in the same cycle. `fifoData` then holds, from MSB to LSB: the packet (DATA_W bits), the column index (COL_W bits) and that column's captured timestamp (TS_W bits).
- R8: The packet field of the FIFO word equals the selected column's slice of `colData` in the valid cycle. Column c occupies bits [c*DATA_W +: DATA_W] of `colData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colToken | input | NUM_COLS | Per-column token: column has pending data |
| colValid | input | NUM_COLS | Per-column one-cycle answer to a read request |
| colData | input | NUM_COLS*DATA_W | Packed per-column packet buses |
| timestamp | input | TS_W | Free-running time counter |
| readLimit | input | LIMIT_W | Maximum consecutive reads per column (0 acts as 1) |
| fifoFull | input | 1 | Output FIFO cannot accept a word |
| colReadReq | output | NUM_COLS | One-hot read request to a column |
| fifoWrite | output | 1 | Write strobe for the output FIFO |
| fifoData | output | DATA_W+COL_W+TS_W | FIFO word {packet, column index, timestamp} |

## Verification
Two exit conditions can meet in the same cycle. The read count can reach the limit in the very cycle that the last packet makes the column drop its token. In that case the selector must leave once and must still continue from the index after that column. This case arises wherever a column's pending count equals the limit, or is a multiple of it. The stimulus table contains rows built that way. Each row is judged by comparing the stream of FIFO words against an order computed from R3 and R4 alone. A second collision comes from FIFO-full stalls that throttle issuing every third cycle while packets are returning. During those stalls no request may appear, and every returned packet must still be written exactly once.

// File: rtl/secReadoutPkg.sv
package secReadoutPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2
  } drainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // pulse a read request to the selected column
    logic capture;  // write the returned packet into the FIFO
  } drainStrobe_t;

endpackage

// File: rtl/secReadoutDatapath.sv
module secReadoutDatapath
  import secReadoutPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int DATA_W   = 8,
  parameter int TS_W     = 8,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_COLS-1:0]        colToken,
  input  logic [NUM_COLS*DATA_W-1:0] colData,
  input  logic [TS_W-1:0]            timestamp,
  input  drainStrobe_t               strobe,
  input  logic [COL_W-1:0]           selCol,
  output logic [NUM_COLS-1:0]        colReadReq,
  output logic                       fifoWrite,
  output logic [DATA_W+COL_W+TS_W-1:0] fifoData
);

  logic [TS_W-1:0] tsArr [NUM_COLS];

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic            armed;
    logic [TS_W-1:0] tsHeld;

    // capture on first high sample of the token, re-arm once it is low
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed  <= 1'b1;
        tsHeld <= '0;
      end else if (!colToken[c]) begin
        armed <= 1'b1;
      end else if (armed) begin
        armed  <= 1'b0;
        tsHeld <= timestamp;
      end
    end

    assign tsArr[c]      = tsHeld;
    assign colReadReq[c] = strobe.issue && (selCol == COL_W'(c));
  end

  logic [DATA_W-1:0] pickedData;
  assign pickedData = colData[selCol*DATA_W +: DATA_W];

  assign fifoWrite = strobe.capture;
  assign fifoData  = {pickedData, selCol, tsArr[selCol]};

endmodule

// File: rtl/secReadoutControl.sv
module secReadoutControl
  import secReadoutPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int LIMIT_W  = 4,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLS-1:0] colToken,
  input  logic [NUM_COLS-1:0] colValid,
  input  logic                fifoFull,
  input  logic [LIMIT_W-1:0]  readLimit,
  output drainStrobe_t        strobe,
  output logic [COL_W-1:0]    selCol
);

  drainState_t        state;
  logic [LIMIT_W-1:0] readCnt;
  logic [LIMIT_W-1:0] limitEff;
  logic               limitHit;
  logic               tokenCur;
  logic               validCur;
  logic               nextFound;
  logic [COL_W-1:0]   nextCol;

  assign limitEff = (readLimit == '0) ? LIMIT_W'(1) : readLimit;
  assign limitHit = (readCnt >= limitEff);
  assign tokenCur = colToken[selCol];
  assign validCur = colValid[selCol];

  // round-robin search starting after the column last selected
  always_comb begin
    nextFound = 1'b0;
    nextCol   = selCol;
    for (int k = 1; k <= NUM_COLS; k++) begin
      logic [COL_W-1:0] cand;
      cand = COL_W'((int'(selCol) + k) % NUM_COLS);
      if (!nextFound && colToken[cand]) begin
        nextFound = 1'b1;
        nextCol   = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selCol  <= COL_W'(NUM_COLS - 1);
      readCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (nextFound) begin
            selCol  <= nextCol;
            readCnt <= '0;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!tokenCur || limitHit) state <= ST_IDLE;
          else if (!fifoFull)        state <= ST_AWAIT;
        end
        ST_AWAIT: begin
          if (validCur) begin
            readCnt <= readCnt + 1'b1;
            state   <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.issue   = (state == ST_ISSUE) && tokenCur && !limitHit && !fifoFull;
    strobe.capture = (state == ST_AWAIT) && validCur;
  end

endmodule

// File: rtl/secReadoutCtrl.sv
module secReadoutCtrl
  import secReadoutPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int DATA_W   = 8,
  parameter int TS_W     = 8,
  parameter int LIMIT_W  = 4,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int WORD_W  = DATA_W + COL_W + TS_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_COLS-1:0]        colToken,
  input  logic [NUM_COLS-1:0]        colValid,
  input  logic [NUM_COLS*DATA_W-1:0] colData,
  input  logic [TS_W-1:0]            timestamp,
  input  logic [LIMIT_W-1:0]         readLimit,
  input  logic                       fifoFull,
  output logic [NUM_COLS-1:0]        colReadReq,
  output logic                       fifoWrite,
  output logic [WORD_W-1:0]          fifoData
);

  drainStrobe_t     strobe;
  logic [COL_W-1:0] selCol;

  secReadoutControl #(
    .NUM_COLS(NUM_COLS),
    .LIMIT_W (LIMIT_W),
    .COL_W   (COL_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .colToken (colToken),
    .colValid (colValid),
    .fifoFull (fifoFull),
    .readLimit(readLimit),
    .strobe   (strobe),
    .selCol   (selCol)
  );

  secReadoutDatapath #(
    .NUM_COLS(NUM_COLS),
    .DATA_W  (DATA_W),
    .TS_W    (TS_W),
    .COL_W   (COL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .colToken  (colToken),
    .colData   (colData),
    .timestamp (timestamp),
    .strobe    (strobe),
    .selCol    (selCol),
    .colReadReq(colReadReq),
    .fifoWrite (fifoWrite),
    .fifoData  (fifoData)
  );

endmodule

// File: rtl/secReadoutChecker.sv
module secReadoutChecker #(
  parameter int NUM_COLS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_COLS-1:0] colToken,
  input logic [NUM_COLS-1:0] colValid,
  input logic                fifoFull,
  input logic [NUM_COLS-1:0] colReadReq,
  input logic                fifoWrite
);

  // R6: at most one column requested at a time
  a_r6_req_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(colReadReq));

  // R6: FIFO-full blocks issuing
  a_r6_no_req_when_full: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (colReadReq == '0));

  // R6: only token-active columns are requested
  a_r6_req_token_active: assert property (@(posedge clk) disable iff (!rstN)
    ((colReadReq & ~colToken) == '0));

  // R6: a request is a single-cycle pulse, never back to back
  a_r6_req_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (colReadReq != '0) |=> (colReadReq == '0));

  // R7: a FIFO write only accompanies a returned packet
  a_r7_write_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrite |-> (colValid != '0));

  // R1: nothing is written in the cycle right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !fifoWrite);

endmodule

bind secReadoutCtrl secReadoutChecker #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .colToken  (colToken),
  .colValid  (colValid),
  .fifoFull  (fifoFull),
  .colReadReq(colReadReq),
  .fifoWrite (fifoWrite)
);

// File: tb/secReadoutCtrl_test.sv
`timescale 1ns/1ps
module secReadoutCtrl_test;
  localparam int NC = 4;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int LW = 4;
  localparam int CW = 2;
  localparam int WW = DW + CW + TW;

  // row: {pend0, pend1, pend2, pend3, limit, throttle}
  localparam int NROWS = 6;
  localparam logic [20:0] VEC [NROWS] = '{
    {4'd2, 4'd0, 4'd3, 4'd1, 4'd2,  1'b0},
    {4'd5, 4'd5, 4'd0, 4'd0, 4'd3,  1'b1},
    {4'd1, 4'd4, 4'd2, 4'd3, 4'd0,  1'b0},
    {4'd0, 4'd0, 4'd6, 4'd0, 4'd4,  1'b1},
    {4'd3, 4'd3, 4'd3, 4'd3, 4'd3,  1'b0},
    {4'd4, 4'd1, 4'd0, 4'd7, 4'd15, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    colToken;
  logic [NC-1:0]    colValid;
  logic [NC*DW-1:0] colData;
  logic [TW-1:0]    timestamp = '0;
  logic [LW-1:0]    readLimit = 4'd1;
  logic             fifoFull = 1'b0;
  logic [NC-1:0]    colReadReq;
  logic             fifoWrite;
  logic [WW-1:0]    fifoData;

  always #2 clk = ~clk;

  secReadoutCtrl #(.NUM_COLS(NC), .DATA_W(DW), .TS_W(TW), .LIMIT_W(LW)) uut (
    .clk(clk), .rstN(rstN), .colToken(colToken), .colValid(colValid),
    .colData(colData), .timestamp(timestamp), .readLimit(readLimit),
    .fifoFull(fifoFull), .colReadReq(colReadReq), .fifoWrite(fifoWrite),
    .fifoData(fifoData)
  );

  int errors = 0;
  int checks = 0;

  // column model: answers a request one cycle later
  int loadCnt [NC];
  int served  [NC];
  logic [NC-1:0] validR;
  logic [DW-1:0] dataR [NC];

  initial begin
    for (int c = 0; c < NC; c++) begin
      loadCnt[c] = 0;
      served[c]  = 0;
      dataR[c]   = '0;
    end
    validR = '0;
  end

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (colReadReq[c]) begin
        validR[c] <= 1'b1;
        dataR[c]  <= {2'(c), 6'(served[c])};
        served[c] <= served[c] + 1;
      end else begin
        validR[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      colToken[c] = (loadCnt[c] != served[c]);
      colData[c*DW +: DW] = dataR[c];
    end
    colValid = validR;
  end

  // expected stream
  logic [CW-1:0] qCol [$];
  logic [DW-1:0] qData [$];
  logic [TW-1:0] qTs [$];
  logic [TW-1:0] expTs [NC];
  int expSeq [NC];
  int lastPtr = NC - 1;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
  endtask

  // monitor sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoFull) begin
        checks++;
        if (colReadReq != '0) fail("R6", "request while full", int'(colReadReq), 0);
      end
      if (fifoWrite) begin
        checks++;
        if (qCol.size() == 0) begin
          fail("R7", "unexpected write", int'(fifoData), -1);
        end else begin
          logic [CW-1:0] eC;
          logic [DW-1:0] eD;
          logic [TW-1:0] eT;
          eC = qCol.pop_front();
          eD = qData.pop_front();
          eT = qTs.pop_front();
          if (fifoData[TW +: CW] != eC) fail("R3", "column order", int'(fifoData[TW +: CW]), int'(eC));
          checks++;
          if (fifoData[TW+CW +: DW] != eD) fail("R8", "packet field", int'(fifoData[TW+CW +: DW]), int'(eD));
          checks++;
          if (fifoData[TW-1:0] != eT) fail("R2", "timestamp field", int'(fifoData[TW-1:0]), int'(eT));
        end
      end
    end
  end

  // order model from R3/R4/R5
  task automatic buildExpected(input int pend [NC], input int lim);
    int rem [NC];
    int ptr;
    int leff;
    bit any;
    leff = (lim == 0) ? 1 : lim;
    ptr = lastPtr;
    for (int c = 0; c < NC; c++) rem[c] = pend[c];
    any = 1'b1;
    while (any) begin
      int pick;
      pick = -1;
      for (int k = 1; k <= NC; k++) begin
        int cand;
        cand = (ptr + k) % NC;
        if (pick < 0 && rem[cand] > 0) pick = cand;
      end
      if (pick < 0) begin
        any = 1'b0;
      end else begin
        int take;
        take = (rem[pick] < leff) ? rem[pick] : leff;
        for (int j = 0; j < take; j++) begin
          qCol.push_back(CW'(pick));
          qData.push_back({2'(pick), 6'(expSeq[pick])});
          qTs.push_back(expTs[pick]);
          expSeq[pick]++;
        end
        rem[pick] -= take;
        ptr = pick;
      end
    end
    lastPtr = ptr;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fail("ALL", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int c = 0; c < NC; c++) expSeq[c] = 0;

    // R1: reset state
    repeat (3) step();
    checks++;
    if (colReadReq != '0) fail("R1", "request in reset", int'(colReadReq), 0);
    checks++;
    if (fifoWrite) fail("R1", "write in reset", 1, 0);
    rstN = 1'b1;
    repeat (4) begin
      step();
      checks++;
      if (colReadReq != '0 || fifoWrite) fail("R1", "activity with no token", int'(colReadReq), 0);
    end

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      int pend [NC];
      int lim;
      bit thr;
      int cyc;
      for (int c = 0; c < NC; c++) pend[c] = int'(VEC[r][20-4*c -: 4]);
      lim = int'(VEC[r][4:1]);
      thr = VEC[r][0];
      readLimit = LW'(lim);
      fifoFull  = 1'b1;
      // raise tokens in search order, each with its own timestamp (R2)
      for (int k = 1; k <= NC; k++) begin
        int c;
        c = (lastPtr + k) % NC;
        if (pend[c] > 0) begin
          loadCnt[c] += pend[c];
          expTs[c] = timestamp;
          step();
          timestamp = timestamp + 8'd1;
        end
      end
      buildExpected(pend, lim);
      // R6: stalled while full
      step();
      checks++;
      if (colReadReq != '0) fail("R6", "request during load stall", int'(colReadReq), 0);
      cyc = 0;
      while ((qCol.size() != 0 || colToken != '0) && cyc < 2000) begin
        fifoFull = thr ? ((cyc % 3) == 0) : 1'b0;
        timestamp = timestamp + 8'd1;
        step();
        cyc++;
      end
      fifoFull = 1'b0;
      repeat (5) step();
      checks++; // R4/R3: every expected word delivered
      if (qCol.size() != 0) fail("R4", "words missing in row", qCol.size(), 0);
      checks++; // R5: drained columns get no further request
      if (colReadReq != '0 || colToken != '0) fail("R5", "activity after drain", int'(colReadReq), 0);
      while (qCol.size() != 0) begin
        void'(qCol.pop_front());
        void'(qData.pop_front());
        void'(qTs.pop_front());
      end
    end

    // R2: a column reloaded later gets a fresh timestamp
    readLimit = 4'd1;
    timestamp = 8'hA5;
    loadCnt[1] += 1;
    expTs[1] = timestamp;
    step();
    timestamp = 8'h3C;
    begin
      int pend [NC];
      for (int c = 0; c < NC; c++) pend[c] = 0;
      pend[1] = 1;
      buildExpected(pend, 1);
    end
    repeat (10) step();
    checks++;
    if (qCol.size() != 0) fail("R2", "relatch word missing", qCol.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule